// File: doc/BRIEF.md
# Half-Warp Dual-Pipe Dispatch Unit

This block is the issue stage of one processing partition. Each cycle it looks at the warps that are ready to issue and selects at most one. It sends that warp's instruction to one of two 16-lane execution pipes. The first pipe runs floating-point work only. The second pipe runs either floating-point or integer work, and the class is chosen per instruction. A 32-thread warp holds its pipe for two back-to-back cycles. The low lane group (threads 0-15) goes out in the first cycle and the high lane group (threads 16-31) in the second. Because a new instruction can start every cycle and each pipe is tied up for two, alternating between the pipes keeps both of them full.

Each pipe has its own two-state controller, `pipe_state_e`:
- `PS_IDLE` is free.
- `PS_SECOND` is busy sending the high half.

Transitions:
- `PS_IDLE -> PS_SECOND` on a start.
- `PS_SECOND -> PS_IDLE` unconditionally.
- `PS_IDLE -> PS_IDLE` with no start.

The low half leaves the block combinationally in the same cycle the warp is selected, together with the acknowledge. The high half comes from registers in the following cycle.

Warps are chosen by round-robin. The search begins at the warp after the most recently acknowledged one. A warp takes part only if a pipe is free for its class. As a result, an integer warp that is waiting for the mixed pipe never holds back floating-point warps behind it.

Top module: `half_warp_dispatch`

## Requirements
- R1: On synchronous reset both pipes return to idle and all strobes and acknowledges are low. The round-robin search restarts at warp 0, and the next floating-point issue with both pipes free prefers the floating-point-only pipe.
- R2: In the cycle a warp is acknowledged (bit w of `issue_ack` for warp w), its chosen pipe shows `*_vld`=1 and `*_hi`=0, that warp id, and the low slice of its active mask (bits 15:0). When a pipe's `*_vld` is 0, its `*_wid` and `*_mask` are 0.
- R3: In the next cycle the same pipe shows `*_vld`=1 and `*_hi`=1, the same warp id, and bits 31:16 of that mask. This happens regardless of stall inputs or new requests.
- R4: At most one warp is acknowledged per cycle, and at most one pipe shows a low half in any cycle.
- R5: An integer-class warp (`req_int` bit = 1) only ever goes to the mixed pipe. While that pipe is unavailable the warp waits, and ready floating-point warps may issue ahead of it.
- R6: A pipe sending a high half accepts no new warp in that cycle.
- R7: A floating-point warp goes to whichever pipe is free. When both are free it goes to the pipe that did not receive the previous issue.
- R8: Among eligible warps, the winner is the first found when searching upward, with wraparound, from the warp after the last acknowledged one.
- R9: A half whose mask slice is all zeros still uses its cycle, with `*_vld`=1 and `*_mask`=0.
- R10: A stall input (`fp_stall`, `mx_stall`) high blocks a new low half on that pipe but never blocks a pending high half.
- R11: `mx_is_int` shows the class of the instruction on the mixed pipe during both of its halves, and is 0 when that pipe is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | NUM_WARPS | Ready request per warp |
| req_int | input | NUM_WARPS | Per warp: 1 = integer class, 0 = floating point |
| req_mask | input | NUM_WARPS*WARP_THREADS | Active masks, warp w in bits [w*32 +: 32] |
| fp_stall | input | 1 | Floating-point-only pipe cannot take a new warp |
| mx_stall | input | 1 | Mixed pipe cannot take a new warp |
| issue_ack | output | NUM_WARPS | One-hot acknowledge to the warp starting this cycle |
| fp_vld | output | 1 | Floating-point-only pipe half-warp strobe |
| fp_hi | output | 1 | 0 = lanes 0-15, 1 = lanes 16-31 |
| fp_wid | output | WID_W | Warp id on the floating-point-only pipe |
| fp_mask | output | LANES | Lane mask slice on the floating-point-only pipe |
| mx_vld | output | 1 | Mixed pipe half-warp strobe |
| mx_hi | output | 1 | 0 = lanes 0-15, 1 = lanes 16-31 |
| mx_wid | output | WID_W | Warp id on the mixed pipe |
| mx_mask | output | LANES | Lane mask slice on the mixed pipe |
| mx_is_int | output | 1 | Mixed pipe instruction is integer class |

## Verification
The hardest case to reach from the ports is an integer warp that is eligible but blocked while the mixed pipe is sending a high half, with a floating-point warp of higher round-robin rank bypassing it in the same cycle. The stimulus table gets there by issuing an integer warp to the mixed pipe in one cycle. In the next cycle it raises a second integer warp together with a floating-point warp. It then checks that the floating-point warp wins and that the integer warp is granted one cycle later. Stall-during-high-half and the steering preference after an issue to the mixed pipe are set up the same way, by choosing which pipe holds a pending high half when a request arrives.

// File: rtl/dpu_pkg.sv
package dpu_pkg;

    typedef enum logic {
        PS_IDLE   = 1'b0,
        PS_SECOND = 1'b1
    } pipe_state_e;

    localparam int PIPE_FP    = 0;
    localparam int PIPE_MX    = 1;
    localparam int NUM_PIPES  = 2;

endpackage

// File: rtl/dpu_rr_arb.sv
module dpu_rr_arb #(
    parameter int N     = 8,
    parameter int WID_W = 3
) (
    input  logic [N-1:0]     elig,
    input  logic [WID_W-1:0] start_ptr,
    output logic             gnt_vld,
    output logic [WID_W-1:0] gnt_wid
);

    // Search begins at start_ptr and wraps; the first eligible entry wins.
    always_comb begin
        gnt_vld = 1'b0;
        gnt_wid = '0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = int'(start_ptr) + k;
            if (idx >= N) begin
                idx = idx - N;
            end
            if (!gnt_vld && elig[idx]) begin
                gnt_vld = 1'b1;
                gnt_wid = idx[WID_W-1:0];
            end
        end
    end

endmodule

// File: rtl/dpu_steer.sv
module dpu_steer
    import dpu_pkg::*;
(
    input  logic                 gnt_vld,
    input  logic                 gnt_int,
    input  logic [NUM_PIPES-1:0] pipe_free,
    input  logic                 last_pipe,
    output logic [NUM_PIPES-1:0] pipe_start
);

    always_comb begin
        pipe_start = '0;
        if (gnt_vld) begin
            if (gnt_int) begin
                pipe_start[PIPE_MX] = 1'b1;
            end else if (pipe_free[PIPE_FP] && pipe_free[PIPE_MX]) begin
                // both open: alternate away from the previous target
                if (last_pipe) begin
                    pipe_start[PIPE_FP] = 1'b1;
                end else begin
                    pipe_start[PIPE_MX] = 1'b1;
                end
            end else if (pipe_free[PIPE_FP]) begin
                pipe_start[PIPE_FP] = 1'b1;
            end else begin
                pipe_start[PIPE_MX] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dpu_pipe_ctrl.sv
module dpu_pipe_ctrl
    import dpu_pkg::*;
#(
    parameter int WID_W = 3,
    parameter int LANES = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [WID_W-1:0]   start_wid,
    input  logic [2*LANES-1:0] start_mask,
    output logic               busy,
    output logic               vld,
    output logic               hi,
    output logic [WID_W-1:0]   wid,
    output logic [LANES-1:0]   mask
);

    pipe_state_e          state_q;
    pipe_state_e          state_d;
    logic [WID_W-1:0]     wid_q;
    logic [LANES-1:0]     upper_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE:   state_d = start ? PS_SECOND : PS_IDLE;
            PS_SECOND: state_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_IDLE;
            wid_q   <= '0;
            upper_q <= '0;
        end else begin
            state_q <= state_d;
            if (start) begin
                wid_q   <= start_wid;
                upper_q <= start_mask[2*LANES-1:LANES];
            end
        end
    end

    always_comb begin
        vld  = 1'b0;
        hi   = 1'b0;
        wid  = '0;
        mask = '0;
        unique case (state_q)
            PS_IDLE: begin
                if (start) begin
                    vld  = 1'b1;
                    wid  = start_wid;
                    mask = start_mask[LANES-1:0];
                end
            end
            PS_SECOND: begin
                vld  = 1'b1;
                hi   = 1'b1;
                wid  = wid_q;
                mask = upper_q;
            end
        endcase
    end

    assign busy = (state_q == PS_SECOND);

endmodule

// File: rtl/half_warp_dispatch.sv
module half_warp_dispatch
    import dpu_pkg::*;
#(
    parameter int NUM_WARPS    = 8,
    parameter int WARP_THREADS = 32,
    localparam int WID_W       = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
    localparam int LANES       = WARP_THREADS / 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_WARPS-1:0]            req_valid,
    input  logic [NUM_WARPS-1:0]            req_int,
    input  logic [NUM_WARPS*WARP_THREADS-1:0] req_mask,
    input  logic                            fp_stall,
    input  logic                            mx_stall,
    output logic [NUM_WARPS-1:0]            issue_ack,
    output logic                            fp_vld,
    output logic                            fp_hi,
    output logic [WID_W-1:0]                fp_wid,
    output logic [LANES-1:0]                fp_mask,
    output logic                            mx_vld,
    output logic                            mx_hi,
    output logic [WID_W-1:0]                mx_wid,
    output logic [LANES-1:0]                mx_mask,
    output logic                            mx_is_int
);

    logic [WID_W-1:0]        rr_ptr_q;
    logic                    last_pipe_q;
    logic                    mx_int_q;

    logic [NUM_PIPES-1:0]    stall_vec;
    logic [NUM_PIPES-1:0]    pipe_busy;
    logic [NUM_PIPES-1:0]    pipe_free;
    logic [NUM_PIPES-1:0]    pipe_start;
    logic [NUM_PIPES-1:0]    pipe_vld;
    logic [NUM_PIPES-1:0]    pipe_hi;
    logic [WID_W-1:0]        pipe_wid  [NUM_PIPES];
    logic [LANES-1:0]        pipe_mask [NUM_PIPES];

    logic [NUM_WARPS-1:0]    elig;
    logic                    gnt_vld;
    logic [WID_W-1:0]        gnt_wid;
    logic                    gnt_int;
    logic [WARP_THREADS-1:0] gnt_mask;

    assign stall_vec = {mx_stall, fp_stall};
    assign pipe_free = ~pipe_busy & ~stall_vec;

    // a warp competes only when some pipe able to run its class is open
    always_comb begin
        for (int w = 0; w < NUM_WARPS; w++) begin
            elig[w] = req_valid[w] && !rst &&
                      (req_int[w] ? pipe_free[PIPE_MX] : (|pipe_free));
        end
    end

    dpu_rr_arb #(
        .N     (NUM_WARPS),
        .WID_W (WID_W)
    ) u_arb (
        .elig      (elig),
        .start_ptr (rr_ptr_q),
        .gnt_vld   (gnt_vld),
        .gnt_wid   (gnt_wid)
    );

    assign gnt_int  = req_int[gnt_wid];
    assign gnt_mask = req_mask[gnt_wid*WARP_THREADS +: WARP_THREADS];

    dpu_steer u_steer (
        .gnt_vld    (gnt_vld),
        .gnt_int    (gnt_int),
        .pipe_free  (pipe_free),
        .last_pipe  (last_pipe_q),
        .pipe_start (pipe_start)
    );

    for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
        dpu_pipe_ctrl #(
            .WID_W (WID_W),
            .LANES (LANES)
        ) u_pipe (
            .clk        (clk),
            .rst        (rst),
            .start      (pipe_start[p]),
            .start_wid  (gnt_wid),
            .start_mask (gnt_mask),
            .busy       (pipe_busy[p]),
            .vld        (pipe_vld[p]),
            .hi         (pipe_hi[p]),
            .wid        (pipe_wid[p]),
            .mask       (pipe_mask[p])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_ptr_q    <= '0;
            last_pipe_q <= 1'b1;
            mx_int_q    <= 1'b0;
        end else begin
            if (gnt_vld) begin
                if (int'(gnt_wid) == NUM_WARPS - 1) begin
                    rr_ptr_q <= '0;
                end else begin
                    rr_ptr_q <= gnt_wid + 1'b1;
                end
                last_pipe_q <= pipe_start[PIPE_MX];
            end
            if (pipe_start[PIPE_MX]) begin
                mx_int_q <= gnt_int;
            end
        end
    end

    always_comb begin
        issue_ack = '0;
        if (gnt_vld) begin
            issue_ack[gnt_wid] = 1'b1;
        end
    end

    assign fp_vld    = pipe_vld[PIPE_FP];
    assign fp_hi     = pipe_hi[PIPE_FP];
    assign fp_wid    = pipe_wid[PIPE_FP];
    assign fp_mask   = pipe_mask[PIPE_FP];
    assign mx_vld    = pipe_vld[PIPE_MX];
    assign mx_hi     = pipe_hi[PIPE_MX];
    assign mx_wid    = pipe_wid[PIPE_MX];
    assign mx_mask   = pipe_mask[PIPE_MX];
    assign mx_is_int = pipe_busy[PIPE_MX] ? mx_int_q
                                          : (pipe_start[PIPE_MX] & gnt_int);

endmodule

// File: rtl/dpu_checker.sv
module dpu_checker #(
    parameter int NUM_WARPS = 8,
    parameter int WID_W     = 3,
    parameter int LANES     = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_WARPS-1:0] req_int,
    input logic [NUM_WARPS-1:0] issue_ack,
    input logic                 fp_stall,
    input logic                 mx_stall,
    input logic                 fp_vld,
    input logic                 fp_hi,
    input logic [WID_W-1:0]     fp_wid,
    input logic [LANES-1:0]     fp_mask,
    input logic                 mx_vld,
    input logic                 mx_hi,
    input logic [WID_W-1:0]     mx_wid,
    input logic [LANES-1:0]     mx_mask,
    input logic                 mx_is_int
);

    AST_FP_HI_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (fp_vld && !fp_hi) |=> (fp_vld && fp_hi && fp_wid == $past(fp_wid))); // R3
    AST_MX_HI_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (mx_vld && !mx_hi) |=> (mx_vld && mx_hi && mx_wid == $past(mx_wid)
                                && mx_is_int == $past(mx_is_int))); // R11
    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(issue_ack)); // R4
    AST_SINGLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !(fp_vld && !fp_hi && mx_vld && !mx_hi)); // R4
    AST_ACK_HAS_LOW: assert property (@(posedge clk) disable iff (rst)
        (|issue_ack) |-> ((fp_vld && !fp_hi) || (mx_vld && !mx_hi))); // R2
    AST_INT_ON_MIXED: assert property (@(posedge clk) disable iff (rst)
        (|(issue_ack & req_int)) |-> (mx_vld && !mx_hi && mx_is_int)); // R5
    AST_FP_NO_START_STALLED: assert property (@(posedge clk) disable iff (rst)
        (fp_vld && !fp_hi) |-> !fp_stall); // R10
    AST_MX_NO_START_STALLED: assert property (@(posedge clk) disable iff (rst)
        (mx_vld && !mx_hi) |-> !mx_stall); // R10
    AST_FP_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !fp_vld |-> (fp_wid == '0 && fp_mask == '0)); // R2
    AST_MX_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !mx_vld |-> (mx_wid == '0 && mx_mask == '0 && !mx_is_int)); // R11

endmodule

bind half_warp_dispatch dpu_checker #(
    .NUM_WARPS (NUM_WARPS),
    .WID_W     (WID_W),
    .LANES     (LANES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_int   (req_int),
    .issue_ack (issue_ack),
    .fp_stall  (fp_stall),
    .mx_stall  (mx_stall),
    .fp_vld    (fp_vld),
    .fp_hi     (fp_hi),
    .fp_wid    (fp_wid),
    .fp_mask   (fp_mask),
    .mx_vld    (mx_vld),
    .mx_hi     (mx_hi),
    .mx_wid    (mx_wid),
    .mx_mask   (mx_mask),
    .mx_is_int (mx_is_int)
);

// File: tb/half_warp_dispatch_tb.sv
module half_warp_dispatch_tb;

    localparam int NW = 8;
    localparam int TH = 32;

    typedef struct packed {
        logic [7:0] val;
        logic [7:0] intc;
        logic [1:0] stall;   // bit0 = fp pipe, bit1 = mixed pipe
        logic [7:0] ack;
        logic       fv;
        logic       fh;
        logic [2:0] fw;
        logic       mv;
        logic       mh;
        logic [2:0] mw;
        logic       mi;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{8'h03, 8'h00, 2'b00, 8'h01, 1'b1,1'b0,3'd0, 1'b0,1'b0,3'd0, 1'b0}, // R1 R7 R8 fp pipe first
        '{8'h02, 8'h02, 2'b00, 8'h02, 1'b1,1'b1,3'd0, 1'b1,1'b0,3'd1, 1'b1}, // R3 R5 int to mixed
        '{8'h0C, 8'h04, 2'b00, 8'h08, 1'b1,1'b0,3'd3, 1'b1,1'b1,3'd1, 1'b1}, // R5 R6 int waits, fp bypasses
        '{8'h04, 8'h04, 2'b00, 8'h04, 1'b1,1'b1,3'd3, 1'b1,1'b0,3'd2, 1'b1}, // R5 waiting int granted
        '{8'h00, 8'h00, 2'b00, 8'h00, 1'b0,1'b0,3'd0, 1'b1,1'b1,3'd2, 1'b1}, // R11 class held
        '{8'h00, 8'h00, 2'b00, 8'h00, 1'b0,1'b0,3'd0, 1'b0,1'b0,3'd0, 1'b0}, // R2 idle zeros
        '{8'h90, 8'h00, 2'b00, 8'h10, 1'b1,1'b0,3'd4, 1'b0,1'b0,3'd0, 1'b0}, // R8 from pointer 3
        '{8'h80, 8'h00, 2'b00, 8'h80, 1'b1,1'b1,3'd4, 1'b1,1'b0,3'd7, 1'b0}, // R7 only mixed free
        '{8'h00, 8'h00, 2'b00, 8'h00, 1'b0,1'b0,3'd0, 1'b1,1'b1,3'd7, 1'b0}, // R3
        '{8'h40, 8'h00, 2'b00, 8'h40, 1'b1,1'b0,3'd6, 1'b0,1'b0,3'd0, 1'b0}, // R7 R8 wrap
        '{8'h00, 8'h00, 2'b00, 8'h00, 1'b1,1'b1,3'd6, 1'b0,1'b0,3'd0, 1'b0}, // R3
        '{8'h20, 8'h00, 2'b00, 8'h20, 1'b0,1'b0,3'd0, 1'b1,1'b0,3'd5, 1'b0}, // R7 R9 alternate, empty low slice
        '{8'h00, 8'h00, 2'b00, 8'h00, 1'b0,1'b0,3'd0, 1'b1,1'b1,3'd5, 1'b0}, // R3
        '{8'h01, 8'h00, 2'b01, 8'h01, 1'b0,1'b0,3'd0, 1'b1,1'b0,3'd0, 1'b0}, // R10 fp stalled
        '{8'h02, 8'h00, 2'b11, 8'h00, 1'b0,1'b0,3'd0, 1'b1,1'b1,3'd0, 1'b0}, // R10 high half ignores stall
        '{8'h02, 8'h00, 2'b01, 8'h02, 1'b0,1'b0,3'd0, 1'b1,1'b0,3'd1, 1'b0}, // R10
        '{8'h00, 8'h00, 2'b00, 8'h00, 1'b0,1'b0,3'd0, 1'b1,1'b1,3'd1, 1'b0}, // R3
        '{8'hFF, 8'h00, 2'b00, 8'h04, 1'b1,1'b0,3'd2, 1'b0,1'b0,3'd0, 1'b0}, // R4 R8 all ready
        '{8'hFB, 8'h00, 2'b00, 8'h08, 1'b1,1'b1,3'd2, 1'b1,1'b0,3'd3, 1'b0}, // R4 R6
        '{8'h00, 8'h00, 2'b00, 8'h00, 1'b0,1'b0,3'd0, 1'b1,1'b1,3'd3, 1'b0}  // R3
    };

    logic              clk = 1'b0;
    logic              rst;
    logic [NW-1:0]     req_valid;
    logic [NW-1:0]     req_int;
    logic [NW*TH-1:0]  req_mask;
    logic              fp_stall;
    logic              mx_stall;
    logic [NW-1:0]     issue_ack;
    logic              fp_vld;
    logic              fp_hi;
    logic [2:0]        fp_wid;
    logic [15:0]       fp_mask;
    logic              mx_vld;
    logic              mx_hi;
    logic [2:0]        mx_wid;
    logic [15:0]       mx_mask;
    logic              mx_is_int;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    half_warp_dispatch #(
        .NUM_WARPS    (NW),
        .WARP_THREADS (TH)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_int   (req_int),
        .req_mask  (req_mask),
        .fp_stall  (fp_stall),
        .mx_stall  (mx_stall),
        .issue_ack (issue_ack),
        .fp_vld    (fp_vld),
        .fp_hi     (fp_hi),
        .fp_wid    (fp_wid),
        .fp_mask   (fp_mask),
        .mx_vld    (mx_vld),
        .mx_hi     (mx_hi),
        .mx_wid    (mx_wid),
        .mx_mask   (mx_mask),
        .mx_is_int (mx_is_int)
    );

    function automatic logic [31:0] mask_of(input int w);
        logic [15:0] lo;
        logic [15:0] up;
        lo = (w == 5) ? 16'h0000 : (16'h5A00 | 16'(w));
        up = 16'hA500 | 16'(w);
        return {up, lo};
    endfunction

    function automatic logic [15:0] exp_slice(input logic v, input logic h, input logic [2:0] w);
        logic [31:0] m;
        m = mask_of(int'(w));
        if (!v) return 16'h0000;
        return h ? m[31:16] : m[15:0];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int w = 0; w < NW; w++) begin
            req_mask[w*TH +: TH] = mask_of(w);
        end
        rst = 1'b1;
        req_valid = '0;
        req_int = '0;
        fp_stall = 1'b0;
        mx_stall = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #4;
        // R1: idle after reset
        chk("R1 reset ack", 32'(issue_ack), 32'h0);
        chk("R1 reset strobes", {28'h0, fp_vld, fp_hi, mx_vld, mx_hi}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            req_valid = VECS[i].val;
            req_int   = VECS[i].intc;
            fp_stall  = VECS[i].stall[0];
            mx_stall  = VECS[i].stall[1];
            #4;
            chk($sformatf("R4 R8 ack vec %0d", i), 32'(issue_ack), 32'(VECS[i].ack));
            chk($sformatf("R2 R3 fp strobe vec %0d", i), {29'h0, fp_vld, fp_hi, 1'b0} | 32'(fp_wid) << 8,
                {29'h0, VECS[i].fv, VECS[i].fh, 1'b0} | 32'(VECS[i].fw) << 8);
            chk($sformatf("R2 R3 mx strobe vec %0d", i), {29'h0, mx_vld, mx_hi, 1'b0} | 32'(mx_wid) << 8,
                {29'h0, VECS[i].mv, VECS[i].mh, 1'b0} | 32'(VECS[i].mw) << 8);
            chk($sformatf("R2 R9 fp mask vec %0d", i), 32'(fp_mask),
                32'(exp_slice(VECS[i].fv, VECS[i].fh, VECS[i].fw)));
            chk($sformatf("R2 R9 mx mask vec %0d", i), 32'(mx_mask),
                32'(exp_slice(VECS[i].mv, VECS[i].mh, VECS[i].mw)));
            chk($sformatf("R11 mx class vec %0d", i), 32'(mx_is_int), 32'(VECS[i].mi));
        end

        // R1: reset in the middle of a warp clears the pipe and the pointer
        @(negedge clk);
        req_valid = 8'h08;
        req_int = '0;
        #4;
        chk("R1 pre-reset issue", 32'(issue_ack), 32'h08);
        @(negedge clk);
        rst = 1'b1;
        req_valid = '0;
        @(negedge clk);
        #4;
        chk("R1 pipes idle in reset", {28'h0, fp_vld, fp_hi, mx_vld, mx_hi}, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        req_valid = 8'hFF;
        #4;
        chk("R1 pointer back to warp 0", 32'(issue_ack), 32'h01);
        chk("R1 R7 fp-only pipe preferred", {30'h0, fp_vld, mx_vld}, 32'h2);

        // R5: integer warp with mixed pipe stalled waits even when fp pipe free
        @(negedge clk);
        req_valid = 8'h02;
        req_int = 8'h02;
        mx_stall = 1'b1;
        @(negedge clk);
        #4;
        chk("R5 int waits for mixed pipe", 32'(issue_ack), 32'h0);
        chk("R5 fp pipe unused by int", 32'(fp_vld), 32'h0);
        @(negedge clk);
        mx_stall = 1'b0;
        #4;
        chk("R5 int issues when mixed opens", 32'(issue_ack), 32'h02);
        chk("R5 R11 int on mixed", {30'h0, mx_vld, mx_is_int}, 32'h3);
        @(negedge clk);
        req_valid = '0;
        req_int = '0;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule